// File: doc/BRIEF.md
# Undefined-Opcode Dispatch Controller

This controller sits beside an instruction decoder and takes over whenever the decoder reports an opcode it cannot execute. When that happens, the controller looks at the attached-processor request line in the same cycle. If an external coprocessor is asking for the job, the controller spends one status cycle driving the current workspace pointer onto its bus output. It then gives the memory bus away through a hold acknowledge. When the coprocessor drops its request, the controller returns control and redirects execution to the instruction after the undefined one.

If no coprocessor volunteers, the controller scans a small external table of macro routines. Each entry holds a valid bit, an opcode pattern, a compare mask and an entry address, and the controller reads one entry per clock. The first matching entry redirects execution to its routine, and the controller then stays in a macro-routine state until a return is reported. The return carries a bit that says whether interrupts must be held off for one more instruction. If the scan finds no match, the controller raises an illegal-opcode trap.

Top module: `undef_op_dispatch`

## Requirements
- R1: After reset, busy, status_cycle, hold_ack, redirect_valid, illegal_trap, in_macro and irq_defer are all 0, bus_out is 0 and tbl_idx is 0.
- R2: undef_valid is acted on only while busy is 0. While busy is 1 it starts no new status cycle and no new scan.
- R3: When undef_valid and cop_req are both 1 at a rising edge with busy 0, status_cycle is 1 after that edge for exactly one cycle, with bus_out equal to the cur_wp sampled at that edge.
- R4: The cycle after the status cycle, hold_ack becomes 1, and it stays 1 for as long as cop_req remains 1.
- R5: A rising edge in hold with cop_req at 0 clears hold_ack. The same edge raises redirect_valid for one cycle, with redirect_pc equal to the next_pc captured when the undefined opcode was detected.
- R6: When undef_valid is 1 and cop_req is 0 with busy 0, the controller scans the table from index 0, one entry per clock, on tbl_idx. Entry i matches when tbl_valid is 1 and ((opcode XOR tbl_pattern) AND tbl_mask) is zero, where a mask bit of 1 means the bit is compared. A match at entry i raises redirect_valid with redirect_pc equal to tbl_entry after the (i+2)-th rising edge, counting the edge that sampled undef_valid as the first.
- R7: When several entries match, the one with the lowest index wins.
- R8: When no entry matches, illegal_trap pulses for one cycle after the (TBL_DEPTH+1)-th rising edge, and busy is 0 in that same cycle.
- R9: After a macro match, in_macro stays 1 until ret_valid is seen. The edge that sees ret_valid clears in_macro and busy and pulses irq_defer for one cycle with the value of ret_block_irq. ret_valid outside the macro state has no effect.
- R10: bus_out is 0 in every cycle that is not a status cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| undef_valid | input | 1 | Decoder reports an undefined opcode |
| undef_opcode | input | OP_W | The undefined opcode |
| cur_wp | input | ADDR_W | Current workspace pointer |
| next_pc | input | ADDR_W | Address of the following instruction |
| cop_req | input | 1 | Attached-processor request |
| ret_valid | input | 1 | Macro routine has executed its return |
| ret_block_irq | input | 1 | Return asks to hold interrupts off for one instruction |
| tbl_idx | output | IDX_W | Table entry being read |
| tbl_valid | input | 1 | Entry is in use |
| tbl_pattern | input | OP_W | Entry opcode pattern |
| tbl_mask | input | OP_W | Entry compare mask |
| tbl_entry | input | ADDR_W | Entry routine address |
| busy | output | 1 | Controller owns the core; fetch stalls |
| status_cycle | output | 1 | Workspace pointer is on bus_out |
| bus_out | output | ADDR_W | Status bus value |
| hold_ack | output | 1 | Memory bus is released to the coprocessor |
| redirect_valid | output | 1 | One-cycle fetch redirect |
| redirect_pc | output | ADDR_W | Redirect target |
| illegal_trap | output | 1 | No handler found |
| in_macro | output | 1 | A macro routine is executing |
| irq_defer | output | 1 | One-cycle pulse: hold off interrupt acceptance |

## Verification
All outputs are registered, so every result appears after a counted number of rising edges. The status cycle appears one edge after detection, and hold starts one edge after that. The release redirect comes one edge after cop_req falls, and the return pulse one edge after ret_valid. A match at entry i comes i+2 edges after detection, and the trap comes TBL_DEPTH+1 edges after it. The bench drives inputs on the falling edge and reads outputs on the next falling edge. For scans it counts falling edges until the first redirect or trap, then compares the count with the figure the requirement gives.

// File: rtl/udh_pkg.sv
package udh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ANNOUNCE,
        ST_HOLD,
        ST_SCAN,
        ST_MACRO
    } udh_state_e;

endpackage

// File: rtl/udh_entry_match.sv
// Masked comparison of one table entry against the captured opcode.
module udh_entry_match #(
    parameter int OP_W = 16
) (
    input  logic            entry_valid,
    input  logic [OP_W-1:0] opcode,
    input  logic [OP_W-1:0] pattern,
    input  logic [OP_W-1:0] mask,
    output logic            hit
);
    logic [OP_W-1:0] diff;

    always_comb begin
        diff = (opcode ^ pattern) & mask;
        hit  = entry_valid && (diff == '0);
    end
endmodule

// File: rtl/udh_scan_index.sv
// Successor and end-of-table flag for the scan pointer.
module udh_scan_index #(
    parameter int TBL_DEPTH = 8,
    parameter int IDX_W     = 3
) (
    input  logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] idx_next,
    output logic             idx_last
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TBL_DEPTH - 1);

    always_comb begin
        idx_last = (idx == LAST_IDX);
        idx_next = idx_last ? '0 : IDX_W'(idx + 1'b1);
    end
endmodule

// File: rtl/undef_op_dispatch.sv
module undef_op_dispatch
    import udh_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int OP_W      = 16,
    parameter int TBL_DEPTH = 8,
    localparam int IDX_W    = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              undef_valid,
    input  logic [OP_W-1:0]   undef_opcode,
    input  logic [ADDR_W-1:0] cur_wp,
    input  logic [ADDR_W-1:0] next_pc,
    input  logic              cop_req,
    input  logic              ret_valid,
    input  logic              ret_block_irq,
    output logic [IDX_W-1:0]  tbl_idx,
    input  logic              tbl_valid,
    input  logic [OP_W-1:0]   tbl_pattern,
    input  logic [OP_W-1:0]   tbl_mask,
    input  logic [ADDR_W-1:0] tbl_entry,
    output logic              busy,
    output logic              status_cycle,
    output logic [ADDR_W-1:0] bus_out,
    output logic              hold_ack,
    output logic              redirect_valid,
    output logic [ADDR_W-1:0] redirect_pc,
    output logic              illegal_trap,
    output logic              in_macro,
    output logic              irq_defer
);

    typedef struct packed {
        udh_state_e        st;
        logic [IDX_W-1:0]  idx;
        logic [OP_W-1:0]   op;
        logic [ADDR_W-1:0] resume;
        logic [ADDR_W-1:0] bus;
        logic              status;
        logic              hold;
        logic              redir;
        logic [ADDR_W-1:0] rpc;
        logic              trap;
        logic              defer;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             entry_hit;
    logic [IDX_W-1:0] idx_next;
    logic             idx_last;

    udh_entry_match #(.OP_W(OP_W)) i_match (
        .entry_valid (tbl_valid),
        .opcode      (ctl_q.op),
        .pattern     (tbl_pattern),
        .mask        (tbl_mask),
        .hit         (entry_hit)
    );

    udh_scan_index #(.TBL_DEPTH(TBL_DEPTH), .IDX_W(IDX_W)) i_index (
        .idx      (ctl_q.idx),
        .idx_next (idx_next),
        .idx_last (idx_last)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.status = 1'b0;
        ctl_d.bus    = '0;
        ctl_d.redir  = 1'b0;
        ctl_d.trap   = 1'b0;
        ctl_d.defer  = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (undef_valid) begin
                    ctl_d.op     = undef_opcode;
                    ctl_d.resume = next_pc;
                    ctl_d.idx    = '0;
                    if (cop_req) begin
                        ctl_d.st     = ST_ANNOUNCE;
                        ctl_d.status = 1'b1;
                        ctl_d.bus    = cur_wp;
                    end else begin
                        ctl_d.st = ST_SCAN;
                    end
                end
            end
            ST_ANNOUNCE: begin
                ctl_d.st   = ST_HOLD;
                ctl_d.hold = 1'b1;
            end
            ST_HOLD: begin
                if (!cop_req) begin
                    ctl_d.st    = ST_IDLE;
                    ctl_d.hold  = 1'b0;
                    ctl_d.redir = 1'b1;
                    ctl_d.rpc   = ctl_q.resume;
                end
            end
            ST_SCAN: begin
                if (entry_hit) begin
                    ctl_d.st    = ST_MACRO;
                    ctl_d.redir = 1'b1;
                    ctl_d.rpc   = tbl_entry;
                    ctl_d.idx   = '0;
                end else if (idx_last) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.trap = 1'b1;
                    ctl_d.idx  = '0;
                end else begin
                    ctl_d.idx = idx_next;
                end
            end
            ST_MACRO: begin
                if (ret_valid) begin
                    ctl_d.st    = ST_IDLE;
                    ctl_d.defer = ret_block_irq;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign tbl_idx        = ctl_q.idx;
    assign busy           = (ctl_q.st != ST_IDLE);
    assign in_macro       = (ctl_q.st == ST_MACRO);
    assign status_cycle   = ctl_q.status;
    assign bus_out        = ctl_q.bus;
    assign hold_ack       = ctl_q.hold;
    assign redirect_valid = ctl_q.redir;
    assign redirect_pc    = ctl_q.rpc;
    assign illegal_trap   = ctl_q.trap;
    assign irq_defer      = ctl_q.defer;

endmodule

// File: rtl/undef_op_dispatch_chk.sv
module undef_op_dispatch_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              undef_valid,
    input logic              cop_req,
    input logic [ADDR_W-1:0] cur_wp,
    input logic              ret_valid,
    input logic              busy,
    input logic              status_cycle,
    input logic [ADDR_W-1:0] bus_out,
    input logic              hold_ack,
    input logic              redirect_valid,
    input logic              illegal_trap,
    input logic              in_macro,
    input logic              irq_defer
);

    assert_busy_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy && undef_valid |=> !status_cycle);

    assert_status_wp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        undef_valid && !busy && cop_req |=> status_cycle && bus_out == $past(cur_wp));

    assert_status_to_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        status_cycle |=> !status_cycle && hold_ack);

    assert_hold_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack && cop_req |=> hold_ack);

    assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack && !cop_req |=> !hold_ack && redirect_valid);

    assert_scan_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        undef_valid && !busy && !cop_req |=> busy && !status_cycle);

    assert_trap_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_trap |-> !busy);

    assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({status_cycle, redirect_valid, illegal_trap}));

    assert_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_macro && ret_valid |=> !in_macro && !busy);

    assert_defer_after_macro_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_defer |-> !in_macro && $past(in_macro));

    assert_bus_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !status_cycle |-> bus_out == '0);

endmodule

bind undef_op_dispatch undef_op_dispatch_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .undef_valid    (undef_valid),
    .cop_req        (cop_req),
    .cur_wp         (cur_wp),
    .ret_valid      (ret_valid),
    .busy           (busy),
    .status_cycle   (status_cycle),
    .bus_out        (bus_out),
    .hold_ack       (hold_ack),
    .redirect_valid (redirect_valid),
    .illegal_trap   (illegal_trap),
    .in_macro       (in_macro),
    .irq_defer      (irq_defer)
);

// File: tb/test_undef_op_dispatch.sv
`timescale 1ns/100ps
module test_undef_op_dispatch;
    localparam int AW = 16;
    localparam int OW = 16;
    localparam int TD = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          undef_valid = 1'b0;
    logic [OW-1:0] undef_opcode = '0;
    logic [AW-1:0] cur_wp = '0;
    logic [AW-1:0] next_pc = '0;
    logic          cop_req = 1'b0;
    logic          ret_valid = 1'b0;
    logic          ret_block_irq = 1'b0;
    logic [2:0]    tbl_idx;
    logic          tbl_valid;
    logic [OW-1:0] tbl_pattern, tbl_mask;
    logic [AW-1:0] tbl_entry;
    logic          busy, status_cycle, hold_ack, redirect_valid;
    logic          illegal_trap, in_macro, irq_defer;
    logic [AW-1:0] bus_out, redirect_pc;

    logic          t_v [0:TD-1];
    logic [OW-1:0] t_p [0:TD-1];
    logic [OW-1:0] t_m [0:TD-1];
    logic [AW-1:0] t_e [0:TD-1];

    assign tbl_valid   = t_v[tbl_idx];
    assign tbl_pattern = t_p[tbl_idx];
    assign tbl_mask    = t_m[tbl_idx];
    assign tbl_entry   = t_e[tbl_idx];

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    undef_op_dispatch #(.ADDR_W(AW), .OP_W(OW), .TBL_DEPTH(TD)) i_undef_op_dispatch (
        .clk, .rst_n, .undef_valid, .undef_opcode, .cur_wp, .next_pc, .cop_req,
        .ret_valid, .ret_block_irq, .tbl_idx, .tbl_valid, .tbl_pattern, .tbl_mask,
        .tbl_entry, .busy, .status_cycle, .bus_out, .hold_ack, .redirect_valid,
        .redirect_pc, .illegal_trap, .in_macro, .irq_defer
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic eq(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, req, what, act, exp);
    endtask

    task automatic clear_table();
        for (int i = 0; i < TD; i++) begin
            t_v[i] = 1'b0; t_p[i] = '0; t_m[i] = '0; t_e[i] = '0;
        end
    endtask

    task automatic set_entry(input int i, input logic [OW-1:0] p,
                             input logic [OW-1:0] m, input logic [AW-1:0] e);
        t_v[i] = 1'b1; t_p[i] = p; t_m[i] = m; t_e[i] = e;
    endtask

    task automatic test_reset();
        eq("R1", "busy", busy, 0);
        eq("R1", "status", status_cycle, 0);
        eq("R1", "hold", hold_ack, 0);
        eq("R1", "redirect", redirect_valid, 0);
        eq("R1", "trap", illegal_trap, 0);
        eq("R1", "macro", in_macro, 0);
        eq("R1", "defer", irq_defer, 0);
        eq("R1", "bus", bus_out, 0);
        eq("R1", "idx", tbl_idx, 0);
    endtask

    task automatic test_coproc(input logic [AW-1:0] wp, input logic [AW-1:0] npc,
                               input int hold_cycles);
        @(negedge clk);
        undef_valid = 1'b1; undef_opcode = 16'h0E12; cur_wp = wp; next_pc = npc;
        cop_req = 1'b1;
        @(negedge clk);
        undef_valid = 1'b0; cur_wp = 16'hDEAD;
        eq("R3", "status", status_cycle, 1);
        eq("R3", "bus wp", bus_out, wp);
        eq("R3", "hold early", hold_ack, 0);
        @(negedge clk);
        eq("R4", "hold", hold_ack, 1);
        eq("R3", "status one cycle", status_cycle, 0);
        eq("R10", "bus quiet", bus_out, 0);
        for (int k = 0; k < hold_cycles; k++) begin
            undef_valid = (k == 0);
            @(negedge clk);
            undef_valid = 1'b0;
            eq("R4", "hold kept", hold_ack, 1);
            eq("R2", "no restart", status_cycle, 0);
            eq("R5", "no early redirect", redirect_valid, 0);
        end
        cop_req = 1'b0;
        @(negedge clk);
        eq("R5", "hold dropped", hold_ack, 0);
        eq("R5", "redirect", redirect_valid, 1);
        eq("R5", "resume pc", redirect_pc, npc);
        @(negedge clk);
        eq("R5", "redirect pulse", redirect_valid, 0);
        eq("R5", "idle", busy, 0);
    endtask

    task automatic test_scan(input string req, input logic [OW-1:0] op,
                             input bit exp_hit, input int exp_idx,
                             input logic [AW-1:0] exp_entry);
        int n;
        @(negedge clk);
        undef_valid = 1'b1; undef_opcode = op; next_pc = 16'h0400; cop_req = 1'b0;
        n = 0;
        for (int k = 1; k <= TD + 4; k++) begin
            @(negedge clk);
            undef_valid = 1'b0;
            if (k == 1) begin
                eq("R6", "scan starts busy", busy, 1);
                eq("R6", "scan starts idx0", tbl_idx, 0);
                eq("R6", "no status", status_cycle, 0);
            end
            if (redirect_valid || illegal_trap) begin
                n = k;
                break;
            end
        end
        if (exp_hit) begin
            eq(req, "redirect", redirect_valid, 1);
            eq(req, "edge count", n, exp_idx + 2);
            eq(req, "entry pc", redirect_pc, exp_entry);
            eq("R9", "in macro", in_macro, 1);
        end else begin
            eq("R8", "trap", illegal_trap, 1);
            eq("R8", "edge count", n, TD + 1);
            eq("R8", "idle at trap", busy, 0);
            @(negedge clk);
            eq("R8", "trap pulse", illegal_trap, 0);
        end
    endtask

    task automatic test_return(input bit blk, input int wait_cycles);
        for (int k = 0; k < wait_cycles; k++) begin
            @(negedge clk);
            eq("R9", "macro held", in_macro, 1);
            eq("R9", "busy in macro", busy, 1);
        end
        ret_valid = 1'b1; ret_block_irq = blk;
        @(negedge clk);
        ret_valid = 1'b0; ret_block_irq = 1'b0;
        eq("R9", "macro left", in_macro, 0);
        eq("R9", "idle", busy, 0);
        eq("R9", "defer", irq_defer, blk);
        @(negedge clk);
        eq("R9", "defer pulse", irq_defer, 0);
    endtask

    task automatic test_stray_return();
        @(negedge clk);
        ret_valid = 1'b1; ret_block_irq = 1'b1;
        @(negedge clk);
        ret_valid = 1'b0; ret_block_irq = 1'b0;
        eq("R9", "stray return defer", irq_defer, 0);
        eq("R9", "stray return busy", busy, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        clear_table();
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();

        test_coproc(16'h8300, 16'h1002, 3);
        test_coproc(16'h00A0, 16'hFFFE, 0);

        set_entry(0, 16'h0C00, 16'hFFF0, 16'h2000);
        set_entry(3, 16'h0D40, 16'hFFFF, 16'h2300);
        set_entry(5, 16'h0D00, 16'hFF00, 16'h2500);
        set_entry(7, 16'h0FFF, 16'hFFFF, 16'h2700);
        t_v[6] = 1'b0; t_p[6] = 16'h0E77; t_m[6] = 16'hFFFF; t_e[6] = 16'h2600;

        test_scan("R6", 16'h0C05, 1'b1, 0, 16'h2000);
        test_return(1'b1, 2);
        test_scan("R7", 16'h0D40, 1'b1, 3, 16'h2300);
        test_return(1'b0, 0);
        test_scan("R6", 16'h0D99, 1'b1, 5, 16'h2500);
        test_return(1'b1, 1);
        test_scan("R6", 16'h0FFF, 1'b1, 7, 16'h2700);
        test_return(1'b0, 3);
        test_scan("R8", 16'h0E77, 1'b0, 0, 16'h0000);
        test_stray_return();
        test_coproc(16'h1234, 16'h5678, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule